// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block derives the serial clock of an I2C controller from the module clock. A prescaler first divides the module clock. Two phase counters then time the low and the high halves of SCL in prescaled ticks. Each half is lengthened by a fixed offset that depends on the prescaler setting. The SCL period in module-clock cycles is therefore (prescale + 1) x ((low_div + d) + (high_div + d)). A build parameter selects a variant whose offset is always 6.

The surrounding controller enables the divider with a run input, which reflects its own out-of-reset control bit. While run is clear, or while the high divider reads zero, SCL stays released (high) and no clock is produced. When the divider starts, it drives the low phase first. The divider settings are taken only at the boundary of a full SCL period, so a running phase is never cut short. A one-cycle strobe marks each falling and each rising SCL edge, so the bit engine can move SDA during low and sample it during high. The prescaler is meant to be set so that the ticks run between 7 and 12 MHz, with the upper end giving more margin.

Top module: `i2c_scl_gen`

## Requirements
- R1: During reset and while `run_i` is 0, `scl_o` is 1 and both strobes are 0.
- R2: When the divider starts, SCL goes low first. The low phase lasts (psc+1)*(low_div+d) module-clock cycles.
- R3: The high phase lasts (psc+1)*(high_div+d) module-clock cycles, and is followed directly by the next low phase while `run_i` stays 1.
- R4: With the default build, d is 7 for psc=0, 6 for psc=1 and 5 for psc>=2.
- R5: With `OFFSET_FIXED6`=1, d is 6 for every psc value.
- R6: If `high_div_i` is 0 at a period boundary, no clock is generated and `scl_o` stays 1.
- R7: `psc_i`, `low_div_i` and `high_div_i` are sampled only when a new period starts (leaving idle, or at the end of a high phase). Changes during a period affect only later periods.
- R8: `scl_fall_o` is 1 for exactly the first low cycle, and `scl_rise_o` is 1 for exactly the first high cycle of each phase. The two strobes are never 1 together.
- R9: Clearing `run_i` releases SCL at the next clock edge, with no rise strobe. A later restart begins with a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Divider enable (controller out of reset) |
| psc_i | input | PSC_W | Prescaler value; tick every psc+1 cycles |
| low_div_i | input | DIV_W | Low-phase divider |
| high_div_i | input | DIV_W | High-phase divider; 0 stops the clock |
| scl_o | output | 1 | SCL level, 1 = released |
| scl_fall_o | output | 1 | One-cycle strobe on the first low cycle |
| scl_rise_o | output | 1 | One-cycle strobe on the first high cycle |

## Verification
The bench builds two copies with PSC_W=3 and DIV_W=6 and drives both from the same stimulus. One copy uses the prescaler-dependent offset and the other uses the fixed offset of 6. The narrow widths keep the longest possible period near a thousand cycles. This puts the largest prescaler and divider values within reach, alongside the psc values 0, 1 and 2 where the offset changes. The same narrow widths let many random settings and the mid-period reprogramming and abort cases fit into a short run.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Fixed per-phase stretch in prescaled ticks.
  function automatic logic [2:0] phase_offset(input logic psc_zero,
                                              input logic psc_one,
                                              input logic fixed6);
    if (fixed6)        return 3'd6;
    else if (psc_zero) return 3'd7;
    else if (psc_one)  return 3'd6;
    else               return 3'd5;
  endfunction

endpackage

// File: rtl/i2c_sclgen_presc.sv
module i2c_sclgen_presc #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [PSC_W-1:0] limit,
  output logic             tick
);
  logic [PSC_W-1:0] cnt_q;

  assign tick = en && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else if (en)      cnt_q <= cnt_q + PSC_W'(1);
  end

  // Tick spacing must be exactly limit+1 cycles.
  assert_presc_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

endmodule

// File: rtl/i2c_sclgen_phase.sv
module i2c_sclgen_phase #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [LEN_W-1:0] last,
  output logic             done
);
  logic [LEN_W-1:0] cnt_q;

  assign done = tick && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (done)   cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + LEN_W'(1);
  end

  // A phase never runs past its terminal count.
  assert_phase_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_sclgen_pkg::*;
#(
  parameter int PSC_W         = 8,
  parameter int DIV_W         = 16,
  parameter bit OFFSET_FIXED6 = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [DIV_W-1:0] low_div_i,
  input  logic [DIV_W-1:0] high_div_i,
  output logic             scl_o,
  output logic             scl_fall_o,
  output logic             scl_rise_o
);
  localparam int LEN_W = DIV_W + 1;

  phase_e           state_q, state_d;
  logic [PSC_W-1:0] psc_q;
  logic [DIV_W-1:0] low_q, high_q;
  logic [2:0]       d_q;
  logic [LEN_W-1:0] len_m1;

  // Named internal events.
  logic tick, phase_done, period_edge, want_start, load_cfg, cnt_clr, active;

  assign active      = (state_q != PH_IDLE);
  assign want_start  = run_i && (high_div_i != '0);
  assign period_edge = (state_q == PH_IDLE) || ((state_q == PH_HIGH) && phase_done);
  assign load_cfg    = period_edge && want_start;

  always_comb begin
    state_d = state_q;
    if (!run_i) begin
      state_d = PH_IDLE;
    end else begin
      unique case (state_q)
        PH_IDLE: if (want_start) state_d = PH_LOW;
        PH_LOW:  if (phase_done) state_d = PH_HIGH;
        PH_HIGH: if (phase_done) state_d = want_start ? PH_LOW : PH_IDLE;
        default: state_d = PH_IDLE;
      endcase
    end
  end

  assign cnt_clr = (state_d != state_q) || !active;
  assign len_m1  = LEN_W'((state_q == PH_LOW) ? low_q : high_q)
                 + LEN_W'(d_q) - LEN_W'(1);

  // Shadow copy of the settings, refreshed only at period boundaries.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
      d_q    <= 3'd7;
    end else if (load_cfg) begin
      psc_q  <= psc_i;
      low_q  <= low_div_i;
      high_q <= high_div_i;
      d_q    <= phase_offset(psc_i == '0, psc_i == PSC_W'(1), OFFSET_FIXED6);
    end
  end

  i2c_sclgen_presc #(.PSC_W(PSC_W)) i_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (active),
    .limit (psc_q),
    .tick  (tick)
  );

  i2c_sclgen_phase #(.LEN_W(LEN_W)) i_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .tick  (tick),
    .last  (len_m1),
    .done  (phase_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PH_IDLE;
      scl_o      <= 1'b1;
      scl_fall_o <= 1'b0;
      scl_rise_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      scl_o      <= (state_d != PH_LOW);
      scl_fall_o <= (state_d == PH_LOW) && (state_q != PH_LOW);
      scl_rise_o <= (state_d == PH_HIGH) && (state_q == PH_LOW);
    end
  end

  assert_fall_means_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_o |-> !scl_o);

  assert_rise_means_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_o |-> scl_o);

  assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_fall_o, scl_rise_o}));

  assert_every_fall_marked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |-> scl_fall_o);

  assert_run_clear_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (scl_o && !scl_fall_o && !scl_rise_o));

  assert_zero_high_no_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && (high_div_i == '0)) |=> (scl_o && !scl_fall_o));

  assert_cfg_held_in_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load_cfg) |=> ($stable(psc_q) && $stable(low_q) && $stable(high_q)));

endmodule

// File: tb/test_i2c_scl_gen.sv
module test_i2c_scl_gen;
  localparam int PSC_W = 3;
  localparam int DIV_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic [PSC_W-1:0] psc = '0;
  logic [DIV_W-1:0] lo = '0;
  logic [DIV_W-1:0] hi = '0;
  logic [1:0]       scl, fall, rise;

  always #5 clk = ~clk;

  i2c_scl_gen #(.PSC_W(PSC_W), .DIV_W(DIV_W), .OFFSET_FIXED6(1'b0)) i_i2c_scl_gen (
    .clk(clk), .rst_n(rst_n), .run_i(run), .psc_i(psc), .low_div_i(lo),
    .high_div_i(hi), .scl_o(scl[0]), .scl_fall_o(fall[0]), .scl_rise_o(rise[0]));

  i2c_scl_gen #(.PSC_W(PSC_W), .DIV_W(DIV_W), .OFFSET_FIXED6(1'b1)) i_i2c_scl_gen_fx6 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .psc_i(psc), .low_div_i(lo),
    .high_div_i(hi), .scl_o(scl[1]), .scl_fall_o(fall[1]), .scl_rise_o(rise[1]));

  int n_chk = 0;
  int n_bad = 0;
  int cnt[2]       = '{0, 0};
  int low_meas[2]  = '{0, 0};
  int high_meas[2] = '{0, 0};
  int nfall[2]     = '{0, 0};
  int nrise[2]     = '{0, 0};

  // Phase length monitor, sampled on the falling clock edge.
  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (fall[k]) begin
        high_meas[k] = cnt[k]; cnt[k] = 1; nfall[k]++;
      end else if (rise[k]) begin
        low_meas[k] = cnt[k]; cnt[k] = 1; nrise[k]++;
      end else begin
        cnt[k]++;
      end
    end
  end

  function automatic int exp_d(int p, bit fx6);
    if (fx6) return 6;
    case (p)
      0:       return 7;
      1:       return 6;
      default: return 5;
    endcase
  endfunction

  function automatic int exp_len(int p, int div, bit fx6);
    return (p + 1) * (div + exp_d(p, fx6));
  endfunction

  task automatic check_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_fall(int k, int tgt);
    while (nfall[k] < tgt) @(posedge clk);
    #1;
  endtask

  task automatic wait_rise(int k, int tgt);
    while (nrise[k] < tgt) @(posedge clk);
    #1;
  endtask

  // Run one full period on both copies and compare both phase lengths.
  task automatic one_period(string req, int p, int l, int h);
    int f0 = nfall[0];
    int f1 = nfall[1];
    psc = PSC_W'(p); lo = DIV_W'(l); hi = DIV_W'(h);
    run = 1'b1;
    wait_fall(0, f0 + 2);
    wait_fall(1, f1 + 2);
    check_eq(req, $sformatf("low p=%0d l=%0d", p, l), low_meas[0], exp_len(p, l, 1'b0));
    check_eq(req, $sformatf("high p=%0d h=%0d", p, h), high_meas[0], exp_len(p, h, 1'b0));
    check_eq("R5", $sformatf("fixed low p=%0d", p), low_meas[1], exp_len(p, l, 1'b1));
    check_eq("R5", $sformatf("fixed high p=%0d", p), high_meas[1], exp_len(p, h, 1'b1));
    run = 1'b0;
    cycles(1);
    check_eq("R9", "scl after run clear", int'(scl), 3);
    cycles(3);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int f0, r0;
    void'($urandom(32'd4711));
    cycles(3);
    // R1: reset state
    check_eq("R1", "scl in reset", int'(scl), 3);
    check_eq("R1", "strobes in reset", int'({fall, rise}), 0);
    rst_n = 1'b1;
    psc = 3'd2; lo = 6'd4; hi = 6'd4;
    cycles(20);
    check_eq("R1", "scl with run low", int'(scl), 3);
    check_eq("R1", "no falls with run low", nfall[0] + nfall[1], 0);

    // R6: high divider zero keeps the clock stopped
    hi = '0; run = 1'b1;
    cycles(200);
    check_eq("R6", "falls with zero high", nfall[0] + nfall[1], 0);
    check_eq("R6", "scl with zero high", int'(scl), 3);
    run = 1'b0;
    cycles(2);

    // R4 offset boundaries and R2 low-first
    one_period("R4", 0, 3, 4);
    one_period("R4", 1, 3, 4);
    one_period("R4", 2, 3, 4);
    one_period("R3", 7, 63, 63);
    one_period("R2", 3, 0, 1);

    // R2/R8: first edge after enable is a fall, and its strobe lasts one cycle
    psc = 3'd1; lo = 6'd2; hi = 6'd3;
    f0 = nfall[0]; r0 = nrise[0];
    run = 1'b1;
    @(posedge clk); #1;
    check_eq("R2", "scl low first", int'(scl[0]), 0);
    check_eq("R8", "fall strobe set", int'(fall[0]), 1);
    cycles(1);
    check_eq("R8", "fall strobe one cycle", int'(fall[0]), 0);
    // R7: reprogram in the middle of the period
    psc = 3'd0; lo = 6'd5; hi = 6'd1;
    wait_rise(0, r0 + 1);
    check_eq("R7", "old low kept", low_meas[0], exp_len(1, 2, 1'b0));
    check_eq("R8", "rise strobe with high", int'(scl[0]), 1);
    wait_fall(0, f0 + 2);
    check_eq("R7", "old high kept", high_meas[0], exp_len(1, 3, 1'b0));
    wait_rise(0, r0 + 2);
    check_eq("R7", "new low applied", low_meas[0], exp_len(0, 5, 1'b0));
    wait_fall(0, f0 + 3);
    check_eq("R3", "new high applied", high_meas[0], exp_len(0, 1, 1'b0));

    // R9: abort in the low phase, then restart
    f0 = nfall[0]; r0 = nrise[0];
    cycles(3);
    run = 1'b0;
    cycles(1);
    check_eq("R9", "released after abort", int'(scl[0]), 1);
    cycles(30);
    check_eq("R9", "no rise on abort", nrise[0], r0);
    psc = 3'd2; lo = 6'd6; hi = 6'd2;
    run = 1'b1;
    wait_rise(0, r0 + 1);
    check_eq("R9", "full low after restart", low_meas[0], exp_len(2, 6, 1'b0));
    run = 1'b0;
    cycles(5);

    // Random settings
    for (int t = 0; t < 24; t++) begin
      one_period("R3", int'($urandom_range(0, 7)), int'($urandom_range(0, 63)),
                 int'($urandom_range(1, 63)));
    end

    report();
    $finish;
  end

endmodule